// File: doc/BRIEF.md
# Interrupt Level Mask Unit

This block holds the processor's interrupt level mask, a small unsigned level in which a lower number stands for a more urgent request. Each cycle it compares the level of the most urgent pending request, as reported by the interrupt controller, against the mask. It raises a one-cycle accept pulse when the mask is strictly above that level, the request is valid and the global enable flag is set.

Software updates the mask through a write port. Once the mask sits in the upper half of its range, software cannot push it back into the lower half. Any value it writes there is moved up by half the range. When a request is accepted, the hardware loads the accepted level into the mask. This hardware load ignores the software rule and takes precedence over a write in the same cycle. The stored value can always be read back.

Top module: `irq_mask_gate`

## Requirements
- R1: Reset sets the mask to 15 (binary 01111) and holds the accept output low.
- R2: While the stored mask is 0 to 15, a software write of any value from 0 to 31 is stored unchanged at the next clock edge.
- R3: While the stored mask is 16 to 31, a software write of a value from 0 to 15 is stored as that value plus 16 (bit 4 forced to 1).
- R4: While the stored mask is 16 to 31, a software write of a value from 16 to 31 is stored unchanged.
- R5: A request is accepted when request-valid is high, the enable flag is high and the mask is numerically greater than the request level. In that case the accept output is high in the cycle after the clock edge that sampled them, and only for that one cycle.
- R6: A request whose level is equal to or greater than the mask is not accepted, and it leaves the mask as it was.
- R7: While the enable flag is low, no request is accepted.
- R8: While request-valid is low, no request is accepted.
- R9: On acceptance the mask is loaded with the accepted request level exactly, without the upper-half write adjustment.
- R10: When a software write and an acceptance fall in the same cycle, the mask takes the accepted level and the write is discarded.
- R11: The read port shows the stored mask, which after an adjusted write is the adjusted value and not the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software write strobe for the mask |
| wr_level | input | 5 | Value written by software |
| req_valid | input | 1 | A request is pending from the interrupt controller |
| req_level | input | 5 | Level of the most urgent pending request |
| irq_enable | input | 1 | Global interrupt enable flag |
| accept | output | 1 | Registered one-cycle acceptance pulse |
| mask_level | output | 5 | Current stored mask |

## Verification
The checker assumes that the request level and request-valid are stable over each sampling edge. It also assumes that the controller keeps the level meaningful only while valid is high, so the mask comparison is taken from port values at the edge. The bench changes every input on the falling clock edge. It holds each set of inputs for exactly one rising edge, which keeps the sampled values unambiguous. It exercises writes in both halves of the range, accepted and refused requests at the equality boundary, and a write that collides with an acceptance.

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_level,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             irq_enable,
  output logic             accept,
  output logic [LVL_W-1:0] mask_level
);

  localparam logic [LVL_W-1:0] RST_LVL = {1'b0, {(LVL_W-1){1'b1}}};

  logic [LVL_W-1:0] mask_q;
  logic             acc_q;
  logic             take;
  logic [LVL_W-1:0] sw_val;

  assign take   = req_valid && irq_enable && (mask_q > req_level);
  assign sw_val = mask_q[LVL_W-1] ? {1'b1, wr_level[LVL_W-2:0]} : wr_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_LVL;
      acc_q  <= 1'b0;
    end else begin
      acc_q <= take;
      if (take)
        mask_q <= req_level;
      else if (wr_en)
        mask_q <= sw_val;
    end
  end

  assign accept     = acc_q;
  assign mask_level = mask_q;

endmodule

// File: rtl/irq_mask_gate_chk.sv
module irq_mask_gate_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [LVL_W-1:0] wr_level,
  input logic             req_valid,
  input logic [LVL_W-1:0] req_level,
  input logic             irq_enable,
  input logic             accept,
  input logic [LVL_W-1:0] mask_level
);

  logic hit;
  assign hit = req_valid && irq_enable && (mask_level > req_level);

  a_r5_accept_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> accept);

  a_r6_no_accept_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !accept);

  a_r7_enable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |=> !accept);

  a_r9_load_level: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> mask_level == $past(req_level));

  a_r3_upper_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && wr_en && mask_level[LVL_W-1]) |=>
      (mask_level == {1'b1, $past(wr_level[LVL_W-2:0])}));

  a_r2_lower_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && wr_en && !mask_level[LVL_W-1]) |=> (mask_level == $past(wr_level)));

  a_r6_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !wr_en) |=> $stable(mask_level));

endmodule

bind irq_mask_gate irq_mask_gate_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_level(wr_level),
  .req_valid(req_valid), .req_level(req_level), .irq_enable(irq_enable),
  .accept(accept), .mask_level(mask_level)
);

// File: tb/irq_mask_gate_tb.sv
module irq_mask_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_level = '0;
  logic       req_valid = 1'b0;
  logic [4:0] req_level = '0;
  logic       irq_enable = 1'b0;
  logic       accept;
  logic [4:0] mask_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] model_mask = 5'd15;

  bit         q_acc[$];
  logic [4:0] q_mask[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  irq_mask_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_level(wr_level),
    .req_valid(req_valid), .req_level(req_level), .irq_enable(irq_enable),
    .accept(accept), .mask_level(mask_level)
  );

  task automatic step(input bit we, input logic [4:0] wv, input bit rv,
                      input logic [4:0] rl, input bit en, input string tag);
    bit         hit;
    logic [4:0] nm;
    @(negedge clk);
    wr_en = we; wr_level = wv; req_valid = rv; req_level = rl; irq_enable = en;
    hit = rv && en && (model_mask > rl);
    if (hit) nm = rl;
    else if (we) nm = (model_mask >= 5'd16) ? (wv | 5'd16) : wv;
    else nm = model_mask;
    model_mask = nm;
    @(posedge clk);
    #1;
    q_acc.push_back(hit);
    q_mask.push_back(nm);
    q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_acc.size() > 0) begin
        bit         ea;
        logic [4:0] em;
        string      t;
        ea = q_acc.pop_front();
        em = q_mask.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (accept !== ea || mask_level !== em) begin
          errors++;
          $display("FAIL %s: accept=%0b mask=%0d expected accept=%0b mask=%0d",
                   t, accept, mask_level, ea, em);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if (accept !== 1'b0 || mask_level !== 5'd15) begin
      errors++;
      $display("FAIL R1: accept=%0b mask=%0d expected accept=0 mask=15", accept, mask_level);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 5'd3,  0, 5'd0,  1, "R2 lower write 3");
    step(1, 5'd20, 0, 5'd0,  1, "R2 lower write 20");
    step(1, 5'd5,  0, 5'd0,  1, "R3 upper write 5");
    step(1, 5'd0,  0, 5'd0,  1, "R3 upper write 0");
    step(1, 5'd31, 0, 5'd0,  1, "R4 upper write 31");
    step(1, 5'd16, 0, 5'd0,  1, "R4 upper write 16");
    step(1, 5'd29, 0, 5'd0,  1, "R4 upper write 29");
    step(0, 5'd0,  1, 5'd25, 1, "R5 accept 25 under 29");
    step(0, 5'd0,  0, 5'd0,  1, "R5 single cycle pulse");
    step(0, 5'd0,  1, 5'd25, 1, "R6 equal level refused");
    step(0, 5'd0,  1, 5'd30, 1, "R6 higher level refused");
    step(0, 5'd0,  1, 5'd2,  0, "R7 enable low");
    step(0, 5'd0,  0, 5'd2,  1, "R8 valid low");
    step(0, 5'd0,  1, 5'd3,  1, "R9 load 3 without adjust");
    step(1, 5'd20, 0, 5'd0,  1, "R11 write 20");
    step(1, 5'd7,  0, 5'd0,  1, "R11 read shows adjusted 23");
    step(1, 5'd31, 1, 5'd10, 1, "R10 accept beats write");
    step(1, 5'd4,  1, 5'd12, 1, "R6 refused request, write lands");
    step(0, 5'd0,  1, 5'd0,  1, "R5 accept level 0");

    @(posedge clk);
    #8;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule